// File: doc/BRIEF.md
# Pair-Latency Operand Scoreboard

This block tracks, for each of 32 general registers, which class of instruction last wrote it and how many cycles ago that write issued. An issue stage reports each instruction it sends: the destination register and a producer class code. Before sending a later instruction, the issue stage asks whether that instruction's source operands are available. It gives up to two source registers, and for each one says how the value will be used: as an execute operand, as a memory address for a load, store or prefetch, or as the data word of a store.

The number of cycles a value needs before a consumer can take it depends on both sides. It depends on the kind of instruction that produced the value and on the way the consumer uses it. Address consumers wait longer for integer results. Store-data consumers skip that extra address delay. A load result can go into the data of a store issued in the same cycle. Each register holds its producer class and a saturating age counter. The query logic compares the age with a latency taken from a (producer, use) table. It also sees an issue made in the same cycle, so a consumer in the same cycle is checked against the newest producer.

Top module: `sb_latency_scoreboard`

## Requirements
- R1: After reset every register reads as ready for every use kind.
- R2: Producer code 0 (load) has a latency of 3 for use kind 1 (address), 0 for use kind 2 (store data) and 1 for use kind 0 (execute). A consumer queried d cycles after the producer's issue cycle (d=0 is the same cycle) is ready exactly when d is at least the latency.
- R3: Producer code 1 (integer ALU) has a latency of 5 for address use and 1 for every other use kind. Use kind 3 is reserved and behaves as execute use.
- R4: Producer code 2 (integer multiply) has a latency of 7 for address use and 3 for execute and store-data use.
- R5: Producer code 3 (move into the FP side) has a latency of 5 and code 4 (move out of the FP side) a latency of 1, whatever the use kind.
- R6: Producer code 5 (FP add/multiply/convert) has a latency of 4 and code 6 (fused multiply-add) a latency of 8, whatever the use kind.
- R7: The long FP operations have fixed latencies: code 7 divide single 24, code 8 divide double 32, code 9 square root single 28, code 10 square root double 40, code 11 reciprocal single 12, code 12 reciprocal double 20.
- R8: Register 0 is always ready, and an issue naming it as the destination has no effect.
- R9: When a register is written again, the newest producer's class and issue cycle alone decide readiness, whether its latency is shorter or longer than the older producer's.
- R10: The ready output is the AND over the enabled sources. A disabled source has no effect, and with no source enabled the output is 1.
- R11: The age counter saturates and does not wrap, so a register stays ready however long it sits idle after its producer's latency has passed.
- R12: Producer codes 13 to 15 are treated with the largest latency, 40, for every use kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 5 | Destination register of the issuing instruction |
| iss_cls | input | 4 | Producer class code of the issuing instruction |
| q_src0_en | input | 1 | Source 0 is present |
| q_src0_idx | input | 5 | Source 0 register |
| q_src0_kind | input | 2 | Source 0 use kind |
| q_src1_en | input | 1 | Source 1 is present |
| q_src1_idx | input | 5 | Source 1 register |
| q_src1_kind | input | 2 | Source 1 use kind |
| q_ready | output | 1 | All enabled sources are available this cycle |

## Verification
The checker watches several properties on every cycle. Register 0 and an empty query always answer ready. A load issued in the same cycle feeds store data at once. A producer whose shortest latency is at least two cycles holds back a consumer in the following cycle. No stored age ever decreases unless its register is written. The exact latency of each (producer, use) pair can only be shown by the bench's scenarios. The same holds for newest-producer-wins on overwrite and for the behaviour after a long idle period. Each scenario issues one producer and polls the query every cycle until it first reports ready.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NREG   = 32;
    localparam int IDX_W  = $clog2(NREG);
    localparam int CLS_W  = 4;
    localparam int KIND_W = 2;
    localparam int LAT_W  = 6;
    localparam int MAX_LAT = 40;

    typedef enum logic [CLS_W-1:0] {
        PC_LOAD    = 4'd0,
        PC_ALU     = 4'd1,
        PC_MUL     = 4'd2,
        PC_TO_FP   = 4'd3,
        PC_FROM_FP = 4'd4,
        PC_FBASIC  = 4'd5,
        PC_FFMA    = 4'd6,
        PC_DIV_S   = 4'd7,
        PC_DIV_D   = 4'd8,
        PC_SQRT_S  = 4'd9,
        PC_SQRT_D  = 4'd10,
        PC_RCP_S   = 4'd11,
        PC_RCP_D   = 4'd12
    } prod_cls_e;

    typedef enum logic [KIND_W-1:0] {
        CK_EXEC   = 2'd0,
        CK_ADDR   = 2'd1,
        CK_STDATA = 2'd2,
        CK_RSVD   = 2'd3
    } cons_kind_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        cons_kind_e       kind;
    } src_query_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] dst;
        prod_cls_e        cls;
    } issue_req_t;

    // Cycles from producer issue until a consumer of the given kind may issue.
    function automatic logic [LAT_W-1:0] pair_latency(prod_cls_e p, cons_kind_e k);
        logic is_addr;
        logic is_stdata;
        is_addr   = (k == CK_ADDR);
        is_stdata = (k == CK_STDATA);
        case (p)
            PC_LOAD:    pair_latency = is_addr ? 6'd3 : (is_stdata ? 6'd0 : 6'd1);
            PC_ALU:     pair_latency = is_addr ? 6'd5 : 6'd1;
            PC_MUL:     pair_latency = is_addr ? 6'd7 : 6'd3;
            PC_TO_FP:   pair_latency = 6'd5;
            PC_FROM_FP: pair_latency = 6'd1;
            PC_FBASIC:  pair_latency = 6'd4;
            PC_FFMA:    pair_latency = 6'd8;
            PC_DIV_S:   pair_latency = 6'd24;
            PC_DIV_D:   pair_latency = 6'd32;
            PC_SQRT_S:  pair_latency = 6'd28;
            PC_SQRT_D:  pair_latency = 6'd40;
            PC_RCP_S:   pair_latency = 6'd12;
            PC_RCP_D:   pair_latency = 6'd20;
            default:    pair_latency = LAT_W'(MAX_LAT);
        endcase
    endfunction

endpackage

// File: rtl/sb_reg_entry.sv
module sb_reg_entry
    import sb_pkg::*;
#(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  prod_cls_e        wr_cls,
    output prod_cls_e        cls_q,
    output logic [AGE_W-1:0] age_q
);
    localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= PC_ALU;
            age_q <= AGE_SAT;
        end else if (wr_en) begin
            cls_q <= wr_cls;
            age_q <= AGE_W'(1);
        end else if (age_q != AGE_SAT) begin
            age_q <= age_q + AGE_W'(1);
        end
    end
endmodule

// File: rtl/sb_src_lookup.sv
module sb_src_lookup
    import sb_pkg::*;
#(
    parameter int AGE_W = 6
) (
    input  src_query_t       q,
    input  issue_req_t       iss,
    input  prod_cls_e        cls_arr [NREG],
    input  logic [AGE_W-1:0] age_arr [NREG],
    output logic             ready
);
    logic             same_cycle;
    prod_cls_e        eff_cls;
    logic [AGE_W-1:0] eff_age;
    logic [LAT_W-1:0] need;

    always_comb begin
        same_cycle = iss.valid && (iss.dst == q.idx) && (q.idx != '0);
        eff_cls    = same_cycle ? iss.cls : cls_arr[q.idx];
        eff_age    = same_cycle ? '0 : age_arr[q.idx];
        need       = pair_latency(eff_cls, q.kind);
        if (!q.en || q.idx == '0)
            ready = 1'b1;
        else
            ready = (eff_age >= AGE_W'(need));
    end
endmodule

// File: rtl/sb_latency_scoreboard.sv
module sb_latency_scoreboard
    import sb_pkg::*;
#(
    parameter int AGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [CLS_W-1:0]  iss_cls,
    input  logic              q_src0_en,
    input  logic [IDX_W-1:0]  q_src0_idx,
    input  logic [KIND_W-1:0] q_src0_kind,
    input  logic              q_src1_en,
    input  logic [IDX_W-1:0]  q_src1_idx,
    input  logic [KIND_W-1:0] q_src1_kind,
    output logic              q_ready
);
    localparam int NSRC = 2;

    initial begin
        if (AGE_W < LAT_W || ((1 << AGE_W) - 1) < MAX_LAT)
            $error("AGE_W too small for the largest latency");
    end

    issue_req_t       iss;
    src_query_t       qs      [NSRC];
    logic [NSRC-1:0]  src_rdy;
    prod_cls_e        cls_arr [NREG];
    logic [AGE_W-1:0] age_q   [NREG];

    assign iss.valid = iss_valid;
    assign iss.dst   = iss_dst;
    assign iss.cls   = prod_cls_e'(iss_cls);

    assign qs[0] = '{en: q_src0_en, idx: q_src0_idx, kind: cons_kind_e'(q_src0_kind)};
    assign qs[1] = '{en: q_src1_en, idx: q_src1_idx, kind: cons_kind_e'(q_src1_kind)};

    // Register 0 is hard-wired ready; the others keep class and age.
    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            if (r == 0) begin : g_zero
                assign cls_arr[r] = PC_ALU;
                assign age_q[r]   = {AGE_W{1'b1}};
            end else begin : g_live
                sb_reg_entry #(.AGE_W(AGE_W)) u_entry (
                    .clk   (clk),
                    .rst   (rst),
                    .wr_en (iss.valid && (iss.dst == IDX_W'(r))),
                    .wr_cls(iss.cls),
                    .cls_q (cls_arr[r]),
                    .age_q (age_q[r])
                );
            end
        end
    endgenerate

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            sb_src_lookup #(.AGE_W(AGE_W)) u_look (
                .q      (qs[s]),
                .iss    (iss),
                .cls_arr(cls_arr),
                .age_arr(age_q),
                .ready  (src_rdy[s])
            );
        end
    endgenerate

    assign q_ready = &src_rdy;

endmodule

// File: rtl/sb_latency_checker.sv
module sb_latency_checker
    import sb_pkg::*;
#(
    parameter int AGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic [IDX_W-1:0]  iss_dst,
    input logic [CLS_W-1:0]  iss_cls,
    input logic              q_src0_en,
    input logic [IDX_W-1:0]  q_src0_idx,
    input logic [KIND_W-1:0] q_src0_kind,
    input logic              q_src1_en,
    input logic              q_ready,
    input logic [AGE_W-1:0]  ages [NREG]
);
    AST_ZERO_REG_READY: assert property (@(posedge clk) disable iff (rst)
        (q_src0_en && q_src0_idx == '0 && !q_src1_en) |-> q_ready); // R8

    AST_EMPTY_QUERY_READY: assert property (@(posedge clk) disable iff (rst)
        (!q_src0_en && !q_src1_en) |-> q_ready); // R10

    AST_LOAD_STDATA_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cls == 4'd0 && iss_dst != '0 && q_src0_en &&
         q_src0_idx == iss_dst && q_src0_kind == 2'd2 && !q_src1_en) |-> q_ready); // R2

    AST_SLOW_PRODUCER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_dst != '0 && (iss_cls == 4'd2 || iss_cls == 4'd3 || iss_cls >= 4'd5))
        |=> ((q_src0_en && q_src0_idx == $past(iss_dst) &&
              !(iss_valid && iss_dst == q_src0_idx)) -> !q_ready)); // R7

    generate
        for (genvar r = 1; r < NREG; r++) begin : g_age
            AST_AGE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
                !(iss_valid && iss_dst == IDX_W'(r)) |=> (ages[r] >= $past(ages[r]))); // R11
        end
    endgenerate
endmodule

bind sb_latency_scoreboard sb_latency_checker #(.AGE_W(AGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_dst    (iss_dst),
    .iss_cls    (iss_cls),
    .q_src0_en  (q_src0_en),
    .q_src0_idx (q_src0_idx),
    .q_src0_kind(q_src0_kind),
    .q_src1_en  (q_src1_en),
    .q_ready    (q_ready),
    .ages       (age_q)
);

// File: tb/sb_latency_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_latency_scoreboard_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [4:0] iss_dst = '0;
    logic [3:0] iss_cls = '0;
    logic       q_src0_en = 1'b0;
    logic [4:0] q_src0_idx = '0;
    logic [1:0] q_src0_kind = '0;
    logic       q_src1_en = 1'b0;
    logic [4:0] q_src1_idx = '0;
    logic [1:0] q_src1_kind = '0;
    logic       q_ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sb_latency_scoreboard u_dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_cls(iss_cls),
        .q_src0_en(q_src0_en), .q_src0_idx(q_src0_idx), .q_src0_kind(q_src0_kind),
        .q_src1_en(q_src1_en), .q_src1_idx(q_src1_idx), .q_src1_kind(q_src1_kind),
        .q_ready(q_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic query0(input logic [4:0] idx, input logic [1:0] kind);
        q_src0_en = 1'b1; q_src0_idx = idx; q_src0_kind = kind; q_src1_en = 1'b0;
    endtask

    // Issue one producer to r9 and poll until the consumer first sees ready.
    task automatic measure(input logic [3:0] cls, input logic [1:0] kind,
                           input int exp, input string req);
        int first;
        first = -1;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd9; iss_cls = cls;
        query0(5'd9, kind);
        for (int d = 0; d < 48; d++) begin
            #0.5;
            if (q_ready && first < 0) first = d;
            @(negedge clk);
            iss_valid = 1'b0;
        end
        check(first == exp, req, first, exp);
    endtask

    task automatic t_reset;
        for (int r = 1; r < 32; r += 10) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                query0(5'(r), 2'(k));
                #0.5;
                check(q_ready == 1'b1, "R1 reset ready", q_ready, 1);
            end
        end
    endtask

    task automatic t_reg0;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd0; iss_cls = 4'd10;
        query0(5'd0, 2'd1);
        #0.5;
        check(q_ready == 1'b1, "R8 reg0 same cycle", q_ready, 1);
        @(negedge clk);
        iss_valid = 1'b0;
        #0.5;
        check(q_ready == 1'b1, "R8 reg0 next cycle", q_ready, 1);
    endtask

    task automatic t_overwrite;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd9; iss_cls = 4'd10; q_src0_en = 1'b0;
        @(negedge clk);
        iss_cls = 4'd1;
        @(negedge clk);
        iss_valid = 1'b0;
        query0(5'd9, 2'd0);
        #0.5;
        check(q_ready == 1'b1, "R9 short over long", q_ready, 1);
        @(negedge clk);
        q_src0_en = 1'b0;
        iss_valid = 1'b1; iss_dst = 5'd10; iss_cls = 4'd1;
        @(negedge clk);
        iss_cls = 4'd2;
        @(negedge clk);
        iss_valid = 1'b0;
        query0(5'd10, 2'd0);
        #0.5;
        check(q_ready == 1'b0, "R9 long over short age1", q_ready, 0);
        @(negedge clk); #0.5;
        check(q_ready == 1'b0, "R9 long over short age2", q_ready, 0);
        @(negedge clk); #0.5;
        check(q_ready == 1'b1, "R9 long over short age3", q_ready, 1);
    endtask

    task automatic t_two_src;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd11; iss_cls = 4'd8; q_src0_en = 1'b0;
        @(negedge clk);
        iss_valid = 1'b0;
        q_src0_en = 1'b1; q_src0_idx = 5'd12; q_src0_kind = 2'd0;
        q_src1_en = 1'b1; q_src1_idx = 5'd11; q_src1_kind = 2'd0;
        #0.5;
        check(q_ready == 1'b0, "R10 one pending source", q_ready, 0);
        q_src1_en = 1'b0;
        #0.5;
        check(q_ready == 1'b1, "R10 pending source disabled", q_ready, 1);
        q_src0_en = 1'b0; q_src1_en = 1'b1; q_src1_idx = 5'd12;
        #0.5;
        check(q_ready == 1'b1, "R10 src1 only ready", q_ready, 1);
        q_src1_en = 1'b0;
        #0.5;
        check(q_ready == 1'b1, "R10 no source", q_ready, 1);
    endtask

    task automatic t_saturate;
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd13; iss_cls = 4'd10; q_src0_en = 1'b0;
        @(negedge clk);
        iss_valid = 1'b0;
        repeat (99) @(negedge clk);
        query0(5'd13, 2'd1);
        #0.5;
        check(q_ready == 1'b1, "R11 ready after 100 idle", q_ready, 1);
        repeat (30) @(negedge clk);
        #0.5;
        check(q_ready == 1'b1, "R11 ready after 130 idle", q_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        measure(4'd0, 2'd1, 3, "R2 load->addr");
        measure(4'd0, 2'd2, 0, "R2 load->stdata");
        measure(4'd0, 2'd0, 1, "R2 load->exec");
        measure(4'd1, 2'd1, 5, "R3 alu->addr");
        measure(4'd1, 2'd0, 1, "R3 alu->exec");
        measure(4'd1, 2'd2, 1, "R3 alu->stdata");
        measure(4'd1, 2'd3, 1, "R3 alu->reserved kind");
        measure(4'd2, 2'd1, 7, "R4 mul->addr");
        measure(4'd2, 2'd0, 3, "R4 mul->exec");
        measure(4'd2, 2'd2, 3, "R4 mul->stdata");
        measure(4'd3, 2'd0, 5, "R5 to-fp exec");
        measure(4'd3, 2'd1, 5, "R5 to-fp addr");
        measure(4'd4, 2'd0, 1, "R5 from-fp exec");
        measure(4'd4, 2'd1, 1, "R5 from-fp addr");
        measure(4'd5, 2'd0, 4, "R6 fp basic");
        measure(4'd6, 2'd2, 8, "R6 fma");
        measure(4'd7, 2'd0, 24, "R7 div single");
        measure(4'd8, 2'd0, 32, "R7 div double");
        measure(4'd9, 2'd1, 28, "R7 sqrt single");
        measure(4'd10, 2'd0, 40, "R7 sqrt double");
        measure(4'd11, 2'd0, 12, "R7 recip single");
        measure(4'd12, 2'd2, 20, "R7 recip double");
        measure(4'd14, 2'd0, 40, "R12 undefined code");
        t_reg0();
        t_overwrite();
        t_two_src();
        t_saturate();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule